// File: doc/BRIEF.md
# Interrupt Source Event-State Controller

This block holds a two-bit event state for each of a set of interrupt sources and decides whether an incoming event goes on to the interrupt router. Bit 1 of the state (P) marks an event that has been forwarded and is waiting for end-of-interrupt (EOI). Bit 0 (Q) records that another event arrived while P was set. A source therefore reaches the router at most once until software finishes with it. When an EOI finds Q set, the source is forwarded again. Events come from a hardware trigger vector, from stores to the register window, or from software EOI.

Each source owns a window of 2^WIN_SHIFT bytes. The window of source n starts at n × 2^WIN_SHIFT. WIN_SHIFT may be 12, 13, 16 or 17. With 13 or 17 the window is split into two halves. The lower half only takes triggers. The upper half, at 2^(WIN_SHIFT−1), carries the management offsets. Loads at the management offsets read the state, set it, or perform EOI, and every load returns the state as it was before the access. Sources marked as level-sensitive also keep an asserted bit that follows their input line. Accepted events are queued per source and presented on a valid/ready notify port, one source at a time, lowest index first.

Top module: `irq_pq_ctrl`

## Requirements
- R1: After reset, every source is in state 00, its asserted bit is 0, ntf_valid is low and rsp_vld is low.
- R2: A trigger moves 00 to 10 and queues a notify. It moves 10 to 11 and leaves 11 and 01 unchanged, and these last three queue no notify.
- R3: A load whose management offset has bits [11:10] = 00 performs EOI. The state goes from 11 to 10 and a notify is queued. From 00, 01 or 10 the state goes to 00 with no notify.
- R4: Every load is answered one cycle later with rsp_vld high and rsp_data = {asserted, P, Q} as they stood before the access. Management offsets with bits [11:10] = 10 or 01 only read. Stores never raise rsp_vld.
- R5: A load with offset bits [11:10] = 11 sets the state to offset bits [9:8].
- R6: A store with offset bits [11:10] = 01 performs EOI when cfg_store_eoi is 1 and has no effect when it is 0.
- R7: A store with offset bits [11:10] = 10 in the management half injects a trigger. Stores with bits [11:10] of 00 or 11 have no effect.
- R8: The source number is bus_addr >> WIN_SHIFT. In two-page mode, bit WIN_SHIFT−1 selects the management half. In the trigger half, a store at any offset is a trigger and a load has no effect. Address bits [7:0] are ignored.
- R9: For a level-sensitive source, the asserted bit follows the input one cycle late. A rising input is a trigger. An EOI while the asserted bit is 1 applies a trigger after the EOI.
- R10: While cfg_pq_off is 1, every trigger queues a notify and leaves the state unchanged.
- R11: Queued notifies are presented lowest source first. ntf_valid stays high until accepted with ntf_ready, and a stalled ntf_src can change only to a lower index.
- R12: When a register access and a hardware trigger hit the same source in one cycle, the access is applied first and the trigger acts on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | NUM_SRC | Hardware triggers: a pulse per event, or a level for level-sensitive sources |
| bus_vld | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address into the source windows |
| cfg_store_eoi | input | 1 | Enables EOI by store |
| cfg_pq_off | input | 1 | Forwards every trigger without consulting the state |
| ntf_ready | input | 1 | Router accepts the presented source |
| ntf_valid | output | 1 | A source notify is presented |
| ntf_src | output | SRC_W | Presented source number |
| rsp_vld | output | 1 | Load answer valid |
| rsp_data | output | 3 | Prior {asserted, P, Q} of the loaded source |

## Verification
The assertions check several rules on every cycle. A trigger from idle must reach the pending state with a notify queued. The off state must absorb triggers, and the bypass must leave the state alone. A rising level must leave a source non-idle. Loads must always be answered, and a stalled notify must stay up without moving to a higher source. The bench scenarios cover what needs a sequence of steps. These include the order of EOI re-notifies and level retriggers, ignored stores with store-EOI disabled, the two-page address split, and an access coinciding with a trigger. They also cover arbitration order under back-pressure, compared against a reference model.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

    typedef logic [1:0] pq_t;

    localparam pq_t PQ_IDLE   = 2'b00;
    localparam pq_t PQ_OFF    = 2'b01;
    localparam pq_t PQ_PEND   = 2'b10;
    localparam pq_t PQ_QUEUED = 2'b11;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_EOI,
        OP_SET,
        OP_TRIG
    } op_e;

    typedef struct packed {
        op_e kind;
        pq_t val;
    } op_t;

    typedef struct packed {
        pq_t  pq;
        logic fire;
    } step_t;

    function automatic step_t pq_on_trigger(pq_t cur, logic bypass);
        step_t r;
        r.pq   = cur;
        r.fire = 1'b0;
        if (bypass) begin
            r.fire = 1'b1;
        end else begin
            case (cur)
                PQ_IDLE: begin
                    r.pq   = PQ_PEND;
                    r.fire = 1'b1;
                end
                PQ_PEND: r.pq = PQ_QUEUED;
                default: r.pq = cur;
            endcase
        end
        return r;
    endfunction

    function automatic step_t pq_on_eoi(pq_t cur);
        step_t r;
        r.fire = (cur == PQ_QUEUED);
        r.pq   = (cur == PQ_QUEUED) ? PQ_PEND : PQ_IDLE;
        return r;
    endfunction

endpackage

// File: rtl/irq_pq_decode.sv
module irq_pq_decode
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int WIN_SHIFT = 13,
    parameter int SRC_W     = 3,
    parameter int ADDR_W    = 16
) (
    input  logic              bus_vld,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              cfg_store_eoi,
    output logic              hit,
    output logic [SRC_W-1:0]  src,
    output op_t               op
);

    localparam bit TWO_PAGE = (WIN_SHIFT == 13) || (WIN_SHIFT == 17);

    logic       mgmt;
    logic [1:0] cls;
    logic       in_range;
    logic       unused_addr;

    assign src         = bus_addr[ADDR_W-1:WIN_SHIFT];
    assign cls         = bus_addr[11:10];
    assign unused_addr = ^bus_addr;

    generate
        if (TWO_PAGE) begin : g_two
            assign mgmt = bus_addr[WIN_SHIFT-1];
        end else begin : g_one
            assign mgmt = 1'b1;
        end
        if (NUM_SRC == (1 << SRC_W)) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = (int'(src) < NUM_SRC);
        end
    endgenerate

    assign hit = bus_vld && in_range;

    always_comb begin
        op.kind = OP_NONE;
        op.val  = bus_addr[9:8];
        if (!mgmt) begin
            op.kind = bus_we ? OP_TRIG : OP_READ;
        end else if (bus_we) begin
            case (cls)
                2'b01:   op.kind = cfg_store_eoi ? OP_EOI : OP_NONE;
                2'b10:   op.kind = OP_TRIG;
                default: op.kind = OP_NONE;
            endcase
        end else begin
            case (cls)
                2'b00:   op.kind = OP_EOI;
                2'b11:   op.kind = OP_SET;
                default: op.kind = OP_READ;
            endcase
        end
    end

endmodule

// File: rtl/irq_pq_cell.sv
module irq_pq_cell
    import irq_pq_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  op_t  op,
    input  logic trig,
    input  logic cfg_pq_off,
    input  logic grant,
    output pq_t  pq,
    output logic asrt,
    output logic req
);

    pq_t   pq_n;
    logic  fire;
    logic  hw_evt;
    logic  busy;
    step_t s;

    assign hw_evt = IS_LEVEL ? (trig & ~asrt) : trig;
    assign busy   = sel && (op.kind != OP_NONE) && (op.kind != OP_READ);

    always_comb begin
        pq_n = pq;
        fire = 1'b0;
        s    = '0;
        if (sel) begin
            case (op.kind)
                OP_SET: pq_n = op.val;
                OP_EOI: begin
                    s    = pq_on_eoi(pq);
                    pq_n = s.pq;
                    fire = s.fire;
                    if (IS_LEVEL && asrt) begin
                        s    = pq_on_trigger(pq_n, cfg_pq_off);
                        pq_n = s.pq;
                        fire = fire | s.fire;
                    end
                end
                OP_TRIG: begin
                    s    = pq_on_trigger(pq, cfg_pq_off);
                    pq_n = s.pq;
                    fire = s.fire;
                end
                default: pq_n = pq;
            endcase
        end
        if (hw_evt) begin
            s    = pq_on_trigger(pq_n, cfg_pq_off);
            pq_n = s.pq;
            fire = fire | s.fire;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pq   <= PQ_IDLE;
            req  <= 1'b0;
            asrt <= 1'b0;
        end else begin
            pq   <= pq_n;
            req  <= (req & ~grant) | fire;
            asrt <= IS_LEVEL ? trig : 1'b0;
        end
    end

    // R2: an idle source hit by a plain trigger becomes pending with a notify queued
    a_r2_idle_trigger_notifies: assert property (@(posedge clk) disable iff (rst)
        (!busy && pq == PQ_IDLE && hw_evt && !cfg_pq_off) |=> (pq == PQ_PEND && req));

    // R2: the off state absorbs triggers
    a_r2_off_absorbs: assert property (@(posedge clk) disable iff (rst)
        (!busy && pq == PQ_OFF) |=> (pq == PQ_OFF));

    // R10: with the check disabled, triggers never move the state
    a_r10_bypass_keeps_state: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_pq_off) |=> $stable(pq));

    // R9: a rising level always leaves the source out of idle
    a_r9_rise_leaves_idle: assert property (@(posedge clk) disable iff (rst)
        (IS_LEVEL && $rose(asrt) && !$past(cfg_pq_off)) |-> (pq != PQ_IDLE));

endmodule

// File: rtl/irq_pq_arb.sv
module irq_pq_arb #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic               ready,
    output logic               valid,
    output logic [SRC_W-1:0]   src,
    output logic [NUM_SRC-1:0] grant
);

    assign valid = |req;

    always_comb begin
        src = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) src = SRC_W'(i);
        end
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_grant
            assign grant[g] = valid && ready && (src == SRC_W'(g));
        end
    endgenerate

    // R11: a stalled notify stays presented
    a_r11_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> valid);

    // R11: a stalled notify may only be overtaken by a lower source
    a_r11_no_higher: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (src <= $past(src)));

endmodule

// File: rtl/irq_pq_ctrl.sv
module irq_pq_ctrl
    import irq_pq_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter int                 WIN_SHIFT  = 13,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
    parameter int                 SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter int                 ADDR_W     = SRC_W + WIN_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] trig_in,
    input  logic               bus_vld,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               cfg_store_eoi,
    input  logic               cfg_pq_off,
    input  logic               ntf_ready,
    output logic               ntf_valid,
    output logic [SRC_W-1:0]   ntf_src,
    output logic               rsp_vld,
    output logic [2:0]         rsp_data
);

    logic               hit;
    logic [SRC_W-1:0]   sel_src;
    op_t                op;
    pq_t                pq_v   [NUM_SRC];
    logic [NUM_SRC-1:0] asrt_v;
    logic [NUM_SRC-1:0] req_v;
    logic [NUM_SRC-1:0] grant_v;

    irq_pq_decode #(
        .NUM_SRC  (NUM_SRC),
        .WIN_SHIFT(WIN_SHIFT),
        .SRC_W    (SRC_W),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .bus_vld      (bus_vld),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .cfg_store_eoi(cfg_store_eoi),
        .hit          (hit),
        .src          (sel_src),
        .op           (op)
    );

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
            irq_pq_cell #(.IS_LEVEL(LEVEL_MASK[g])) u_cell (
                .clk       (clk),
                .rst       (rst),
                .sel       (hit && (sel_src == SRC_W'(g))),
                .op        (op),
                .trig      (trig_in[g]),
                .cfg_pq_off(cfg_pq_off),
                .grant     (grant_v[g]),
                .pq        (pq_v[g]),
                .asrt      (asrt_v[g]),
                .req       (req_v[g])
            );
        end
    endgenerate

    irq_pq_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (req_v),
        .ready(ntf_ready),
        .valid(ntf_valid),
        .src  (ntf_src),
        .grant(grant_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_vld  <= bus_vld && !bus_we;
            rsp_data <= hit ? {asrt_v[sel_src], pq_v[sel_src]} : 3'b000;
        end
    end

    // R4: every load is answered on the next cycle
    a_r4_load_answered: assert property (@(posedge clk) disable iff (rst)
        (bus_vld && !bus_we) |=> rsp_vld);

    // R4: no answer without a load
    a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !(bus_vld && !bus_we) |=> !rsp_vld);

endmodule

// File: tb/sim_irq_pq_ctrl.sv
module sim_irq_pq_ctrl;
    localparam int N  = 8;
    localparam int SH = 13;
    localparam int AW = 16;
    localparam logic [N-1:0] LM = 8'hC0;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic [N-1:0]  trig;
    logic          bus_vld, bus_we;
    logic [AW-1:0] bus_addr;
    logic          cfg_store_eoi, cfg_pq_off, ntf_ready;
    logic          ntf_valid;
    logic [2:0]    ntf_src;
    logic          rsp_vld;
    logic [2:0]    rsp_data;

    irq_pq_ctrl #(.NUM_SRC(N), .WIN_SHIFT(SH), .LEVEL_MASK(LM)) u0 (
        .clk(clk), .rst(rst), .trig_in(trig), .bus_vld(bus_vld), .bus_we(bus_we),
        .bus_addr(bus_addr), .cfg_store_eoi(cfg_store_eoi), .cfg_pq_off(cfg_pq_off),
        .ntf_ready(ntf_ready), .ntf_valid(ntf_valid), .ntf_src(ntf_src),
        .rsp_vld(rsp_vld), .rsp_data(rsp_data)
    );

    logic [1:0]   m_pq [N];
    logic [N-1:0] m_req, m_asrt;
    logic         m_rsp_vld;
    logic [2:0]   m_rsp;
    int nchk = 0, nerr = 0;
    string cur = "R1";

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] lowest(logic [N-1:0] r);
        logic [2:0] s = 3'd0;
        for (int i = N - 1; i >= 0; i--) if (r[i]) s = 3'(i);
        return s;
    endfunction

    function automatic logic [2:0] m_trg(logic [1:0] p);
        if (cfg_pq_off) return {1'b1, p};
        if (p == 2'b00) return 3'b110;
        if (p == 2'b10) return 3'b011;
        return {1'b0, p};
    endfunction

    function automatic logic [2:0] m_eoi(logic [1:0] p);
        return (p == 2'b11) ? 3'b110 : 3'b000;
    endfunction

    task automatic model_step();
        logic [N-1:0] g = '0;
        logic [N-1:0] nreq, nasrt;
        logic [1:0]   npq [N];
        int s;
        logic mg;
        logic [1:0] cls, v;
        if (|m_req && ntf_ready) g[lowest(m_req)] = 1'b1;
        s   = int'(bus_addr[15:13]);
        mg  = bus_addr[12];
        cls = bus_addr[11:10];
        v   = bus_addr[9:8];
        for (int i = 0; i < N; i++) begin
            logic [1:0] p = m_pq[i];
            logic n = 1'b0;
            logic do_eoi = 1'b0;
            logic do_trg = 1'b0;
            logic [2:0] r;
            if (bus_vld && s == i) begin
                if (!mg) begin
                    do_trg = bus_we;
                end else if (bus_we) begin
                    do_eoi = (cls == 2'b01) && cfg_store_eoi;
                    do_trg = (cls == 2'b10);
                end else if (cls == 2'b00) begin
                    do_eoi = 1'b1;
                end else if (cls == 2'b11) begin
                    p = v;
                end
            end
            if (do_eoi) begin
                r = m_eoi(p); p = r[1:0]; n = n | r[2];
                if (LM[i] && m_asrt[i]) begin r = m_trg(p); p = r[1:0]; n = n | r[2]; end
            end
            if (do_trg) begin r = m_trg(p); p = r[1:0]; n = n | r[2]; end
            if (LM[i] ? (trig[i] && !m_asrt[i]) : trig[i]) begin
                r = m_trg(p); p = r[1:0]; n = n | r[2];
            end
            npq[i]   = p;
            nreq[i]  = (m_req[i] & ~g[i]) | n;
            nasrt[i] = LM[i] & trig[i];
        end
        m_rsp_vld = bus_vld && !bus_we;
        m_rsp     = {m_asrt[s], m_pq[s]};
        for (int i = 0; i < N; i++) m_pq[i] = npq[i];
        m_req  = nreq;
        m_asrt = nasrt;
    endtask

    task automatic compare();
        chk(cur, 32'(ntf_valid), 32'(|m_req));
        if (|m_req) chk(cur, 32'(ntf_src), 32'(lowest(m_req)));
        chk(cur, 32'(rsp_vld), 32'(m_rsp_vld));
        if (m_rsp_vld) chk(cur, 32'(rsp_data), 32'(m_rsp));
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic quiet();
        bus_vld = 1'b0; bus_we = 1'b0;
        trig = trig & LM;
    endtask

    task automatic acc(logic we, int src, logic mg, logic [11:0] off);
        bus_vld = 1'b1; bus_we = we;
        bus_addr = {3'(src), mg, off};
        tick();
        quiet();
    endtask

    task automatic read_src(int src);
        acc(1'b0, src, 1'b1, 12'h800);
    endtask

    task automatic pulse(int src);
        trig[src] = 1'b1;
        tick();
        trig[src] = 1'b0;
    endtask

    initial begin
        #1_500_000;
        nerr++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; trig = '0; bus_vld = 1'b0; bus_we = 1'b0; bus_addr = '0;
        cfg_store_eoi = 1'b0; cfg_pq_off = 1'b0; ntf_ready = 1'b1;
        for (int i = 0; i < N; i++) m_pq[i] = 2'b00;
        m_req = '0; m_asrt = '0; m_rsp_vld = 1'b0; m_rsp = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cur = "R1";
        chk("R1", 32'(ntf_valid), 0);
        chk("R1", 32'(rsp_vld), 0);
        read_src(0); chk("R1", 32'(rsp_data), 0);
        read_src(6); chk("R1", 32'(rsp_data), 0);

        // R2: trigger transitions
        cur = "R2";
        ntf_ready = 1'b0;
        pulse(1);
        chk("R2", 32'(ntf_valid), 1);
        chk("R2", 32'(ntf_src), 1);
        ntf_ready = 1'b1; tick();
        pulse(1); pulse(1);
        chk("R2", 32'(ntf_valid), 0);
        read_src(1); chk("R2", 32'(rsp_data), 3'b011);

        // R3: EOI by load, with re-notify from 11
        cur = "R3";
        ntf_ready = 1'b0;
        acc(1'b0, 1, 1'b1, 12'h000);
        chk("R3", 32'(rsp_data), 3'b011);
        chk("R3", 32'(ntf_valid), 1);
        ntf_ready = 1'b1; tick();
        acc(1'b0, 1, 1'b1, 12'h0A5);
        chk("R3", 32'(rsp_data), 3'b010);
        read_src(1); chk("R3", 32'(rsp_data), 3'b000);

        // R5 + R2: set to off, trigger absorbed
        cur = "R5";
        acc(1'b0, 4, 1'b1, 12'hD00);
        pulse(4);
        chk("R2", 32'(ntf_valid), 0);
        read_src(4); chk("R5", 32'(rsp_data), 3'b001);
        acc(1'b0, 4, 1'b1, 12'hE3C);
        read_src(4); chk("R5", 32'(rsp_data), 3'b010);
        acc(1'b0, 4, 1'b1, 12'hC00);

        // R6: store EOI gated by cfg_store_eoi
        cur = "R6";
        acc(1'b0, 3, 1'b1, 12'hF00);
        cfg_store_eoi = 1'b0;
        acc(1'b1, 3, 1'b1, 12'h400);
        read_src(3); chk("R6", 32'(rsp_data), 3'b011);
        chk("R6", 32'(ntf_valid), 0);
        cfg_store_eoi = 1'b1;
        acc(1'b1, 3, 1'b1, 12'h400);
        chk("R6", 32'(ntf_valid), 1);
        tick();
        read_src(3); chk("R6", 32'(rsp_data), 3'b010);

        // R7: inject and ignored stores
        cur = "R7";
        acc(1'b0, 2, 1'b1, 12'hC00);
        acc(1'b1, 2, 1'b1, 12'h000);
        acc(1'b1, 2, 1'b1, 12'hC00);
        chk("R7", 32'(ntf_valid), 0);
        acc(1'b1, 2, 1'b1, 12'h800);
        chk("R7", 32'(ntf_valid), 1);
        tick();

        // R8: trigger half
        cur = "R8";
        acc(1'b0, 5, 1'b0, 12'h000);
        chk("R8", 32'(rsp_data), 3'b000);
        acc(1'b0, 5, 1'b0, 12'hC00);
        read_src(5); chk("R8", 32'(rsp_data), 3'b000);
        acc(1'b1, 5, 1'b0, 12'h123);
        chk("R8", 32'(ntf_src), 5);
        tick();

        // R9: level source
        cur = "R9";
        trig[6] = 1'b1; tick();
        chk("R9", 32'(ntf_src), 6);
        tick();
        read_src(6); chk("R9", 32'(rsp_data), 3'b110);
        acc(1'b0, 6, 1'b1, 12'h000);
        chk("R9", 32'(ntf_valid), 1);
        tick();
        trig[6] = 1'b0; tick();
        acc(1'b0, 6, 1'b1, 12'h000);
        read_src(6); chk("R9", 32'(rsp_data), 3'b000);

        // R10: bypass
        cur = "R10";
        cfg_pq_off = 1'b1;
        pulse(0); tick(); pulse(0);
        chk("R10", 32'(ntf_valid), 1);
        tick();
        read_src(0); chk("R10", 32'(rsp_data), 3'b000);
        cfg_pq_off = 1'b0;
        acc(1'b0, 0, 1'b1, 12'hC00);

        // R11: arbitration under back-pressure
        cur = "R11";
        for (int i = 0; i < N; i++) acc(1'b0, i, 1'b1, 12'hC00);
        ntf_ready = 1'b0;
        trig[5] = 1'b1; trig[2] = 1'b1; tick(); trig[5] = 1'b0; trig[2] = 1'b0;
        tick(); tick();
        chk("R11", 32'(ntf_src), 2);
        ntf_ready = 1'b1; tick();
        chk("R11", 32'(ntf_src), 5);
        tick();
        chk("R11", 32'(ntf_valid), 0);

        // R12: access before hardware trigger in the same cycle
        cur = "R12";
        acc(1'b0, 2, 1'b1, 12'hF00);
        trig[2] = 1'b1;
        acc(1'b0, 2, 1'b1, 12'hC00);
        trig[2] = 1'b0;
        chk("R12", 32'(ntf_valid), 1);
        read_src(2); chk("R12", 32'(rsp_data), 3'b010);

        // R2/R3/R4/R11/R12: random traffic against the model
        cur = "R4 random";
        for (int c = 0; c < 4000; c++) begin
            logic [N-1:0] t;
            t = '0;
            for (int i = 0; i < N; i++) begin
                if (LM[i]) t[i] = (($urandom % 8) == 0) ? ~trig[i] : trig[i];
                else       t[i] = (($urandom % 6) == 0);
            end
            trig = t;
            bus_vld = ($urandom % 2) == 0;
            bus_we = ($urandom % 3) == 0;
            bus_addr = {3'($urandom % 8), 1'(($urandom % 4) != 0), 2'($urandom), 2'($urandom), 8'($urandom)};
            ntf_ready = ($urandom % 4) != 0;
            if (c % 500 == 0) cfg_store_eoi = 1'($urandom);
            cfg_pq_off = (c >= 3000 && c < 3300);
            tick();
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule